// File: doc/BRIEF.md
# DMA Address and Count Sequencer

This block produces the physical memory address of every transfer made by one DMA channel and keeps track of how many transfers remain. A load strobe copies a 16-bit start address and a 16-bit count into working registers. After that, each step strobe advances the address by one and lowers the count by one. The physical address is built from the working address and an 8-bit page value.

In byte mode the page forms the top eight address bits. In word mode the working address is shifted up by one bit so that it spans a 128K region, and page bit 0 is unused. The page never advances, so a run that passes the end of its region wraps back to the start of that same region.

When the count runs out, the block raises a one-cycle terminal-count pulse. It then either halts or, with auto-initialisation set, reloads its start values and keeps going. The remaining count can be read at any time.

The step strobe is a plain control pin rather than a valid/ready stream. A strobe counts whenever the channel is running. A strobe while halted is dropped, and the block never applies back-pressure.

Top module: `dma_addr_seq`

## Requirements
- R1: After reset the working address and count are 0x0000, the channel is halted (`running_o`=0), `tc_o` is 0 and `residue_o` is 0x0001.
- R2: `load_i` copies `base_addr_i` and `base_count_i` into the working registers, sets `running_o` and clears `tc_o` on the next cycle. When `load_i` and `step_i` are high in the same cycle, the load wins and the step is dropped.
- R3: While running, a step raises the working address by 1 with 16-bit wrap and lowers the working count by 1.
- R4: In byte mode (`word_mode_i`=0), `phys_addr_o[23:16]` equals `page_i[7:0]` and `phys_addr_o[15:0]` equals the working address.
- R5: In word mode (`word_mode_i`=1), `phys_addr_o[23:17]` equals `page_i[7:1]`, `phys_addr_o[16:1]` equals the working address, and `phys_addr_o[0]` is 0. Page bit 0 has no effect.
- R6: Stepping from working address 0xFFFF goes to 0x0000, and the page bits of `phys_addr_o` stay unchanged.
- R7: A step taken at working count 0x0000 raises `tc_o` for exactly the next cycle. Without auto-initialisation the count becomes 0xFFFF and `running_o` drops. A loaded count N therefore gives N+1 transfers.
- R8: Step strobes while halted leave the address, the count and `tc_o` unchanged.
- R9: With `auto_init_i`=1, the terminal step reloads the working address and count from the base inputs, and the channel stays running.
- R10: `residue_o` equals the working count plus 1, computed modulo 2^16. It is 0 after a non-reloading terminal count, and 0 right after loading 0xFFFF.
- R11: `lane_o` is 2'b01 in byte mode at an even working address, 2'b10 in byte mode at an odd working address, and 2'b11 in word mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Copy base values into working registers |
| step_i | input | 1 | One transfer done |
| base_addr_i | input | 16 | Start address |
| base_count_i | input | 16 | Transfers minus one |
| page_i | input | 8 | Page bits |
| word_mode_i | input | 1 | 1 = 16-bit transfers |
| auto_init_i | input | 1 | Reload on terminal count |
| phys_addr_o | output | 24 | Physical address of current transfer |
| lane_o | output | 2 | Active byte lanes |
| tc_o | output | 1 | Terminal-count pulse |
| count_o | output | 16 | Working count |
| residue_o | output | 16 | Remaining transfers (count + 1) |
| running_o | output | 1 | Channel accepts steps |

## Verification
Several rules are checked by assertions on every cycle: the decrement and increment on an accepted step, the cause of each terminal pulse, the hold while halted, the auto-initialisation reload, and the effect of a load. The address mapping for both modes, the region wrap, the lane encoding and the residue arithmetic can only be shown by the bench. It sweeps many start counts and addresses in both modes, runs each one to its terminal count, and compares every output against arithmetic expectations.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned PAGE_W = 8;

  typedef enum logic [1:0] {
    LANE_NONE = 2'b00,
    LANE_LOW  = 2'b01,
    LANE_HIGH = 2'b10,
    LANE_BOTH = 2'b11
  } lane_e;
endpackage

// File: rtl/dma_seq_counter.sv
module dma_seq_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             auto_init_i,
  input  logic [CNT_W-1:0] base_addr_i,
  input  logic [CNT_W-1:0] base_count_i,
  output logic [CNT_W-1:0] addr_o,
  output logic [CNT_W-1:0] count_o,
  output logic             tc_o,
  output logic             running_o
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] addr_q, count_q;
  logic             halted_q, tc_q;
  logic             take, last;

  assign take = step_i && !halted_q && !load_i;
  assign last = (count_q == ZERO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= ZERO;
      count_q  <= ZERO;
      halted_q <= 1'b1;
      tc_q     <= 1'b0;
    end else if (load_i) begin
      addr_q   <= base_addr_i;
      count_q  <= base_count_i;
      halted_q <= 1'b0;
      tc_q     <= 1'b0;
    end else begin
      tc_q <= take && last;
      if (take) begin
        if (last && auto_init_i) begin
          addr_q  <= base_addr_i;
          count_q <= base_count_i;
        end else begin
          addr_q  <= addr_q + ONE;
          count_q <= count_q - ONE;
          if (last) halted_q <= 1'b1;
        end
      end
    end
  end

  assign addr_o    = addr_q;
  assign count_o   = count_q;
  assign tc_o      = tc_q;
  assign running_o = !halted_q;

  assert_count_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !last) |=> (count_q == $past(count_q) - ONE));
  assert_addr_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !(last && auto_init_i)) |=> (addr_q == $past(addr_q) + ONE));
  assert_tc_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_q) |-> $past(step_i && !halted_q && !load_i && count_q == ZERO));
  assert_halt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && !load_i) |=> ($stable(addr_q) && $stable(count_q) && !tc_q));
  assert_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && last && auto_init_i) |=>
      (count_q == $past(base_count_i) && addr_q == $past(base_addr_i) && !halted_q));
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (count_q == $past(base_count_i) && !tc_q && !halted_q));
endmodule

// File: rtl/dma_seq_addr_map.sv
module dma_seq_addr_map
  import dma_seq_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PAGE_W = 8
) (
  input  logic [CNT_W-1:0]        addr_i,
  input  logic [PAGE_W-1:0]       page_i,
  input  logic                    word_mode_i,
  output logic [CNT_W+PAGE_W-1:0] phys_o,
  output logic [1:0]              lane_o
);
  localparam int unsigned PHYS_W = CNT_W + PAGE_W;

  logic [PHYS_W-1:0] byte_phys, word_phys;

  assign byte_phys = {page_i, addr_i};
  assign word_phys = {page_i[PAGE_W-1:1], addr_i, 1'b0};

  always_comb begin
    if (word_mode_i) begin
      phys_o = word_phys;
      lane_o = LANE_BOTH;
    end else begin
      phys_o = byte_phys;
      lane_o = addr_i[0] ? LANE_HIGH : LANE_LOW;
    end
  end
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_seq_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic                    step_i,
  input  logic [CNT_W-1:0]        base_addr_i,
  input  logic [CNT_W-1:0]        base_count_i,
  input  logic [PAGE_W-1:0]       page_i,
  input  logic                    word_mode_i,
  input  logic                    auto_init_i,
  output logic [CNT_W+PAGE_W-1:0] phys_addr_o,
  output logic [1:0]              lane_o,
  output logic                    tc_o,
  output logic [CNT_W-1:0]        count_o,
  output logic [CNT_W-1:0]        residue_o,
  output logic                    running_o
);
  logic [CNT_W-1:0] cur_addr;

  dma_seq_counter #(.CNT_W(CNT_W)) u_counter (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_i),
    .step_i       (step_i),
    .auto_init_i  (auto_init_i),
    .base_addr_i  (base_addr_i),
    .base_count_i (base_count_i),
    .addr_o       (cur_addr),
    .count_o      (count_o),
    .tc_o         (tc_o),
    .running_o    (running_o)
  );

  dma_seq_addr_map #(.CNT_W(CNT_W), .PAGE_W(PAGE_W)) u_map (
    .addr_i      (cur_addr),
    .page_i      (page_i),
    .word_mode_i (word_mode_i),
    .phys_o      (phys_addr_o),
    .lane_o      (lane_o)
  );

  assign residue_o = count_o + {{(CNT_W-1){1'b0}}, 1'b1};

  assert_tc_running_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_o && !auto_init_i && !$past(auto_init_i)) |-> (!running_o && residue_o == '0));
endmodule

// File: tb/dma_addr_seq_tb.sv
module dma_addr_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_i = 1'b0, step_i = 1'b0;
  logic [15:0] base_addr_i = '0, base_count_i = '0;
  logic [7:0]  page_i = '0;
  logic        word_mode_i = 1'b0, auto_init_i = 1'b0;
  logic [23:0] phys_addr_o;
  logic [1:0]  lane_o;
  logic        tc_o, running_o;
  logic [15:0] count_o, residue_o;

  int errors = 0;
  int checks = 0;
  int m_addr, m_cnt;
  bit m_run;

  always #5 clk = ~clk;

  dma_addr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .step_i(step_i),
    .base_addr_i(base_addr_i), .base_count_i(base_count_i), .page_i(page_i),
    .word_mode_i(word_mode_i), .auto_init_i(auto_init_i),
    .phys_addr_o(phys_addr_o), .lane_o(lane_o), .tc_o(tc_o),
    .count_o(count_o), .residue_o(residue_o), .running_o(running_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input bit ld, input bit st);
    load_i = ld;
    step_i = st;
    @(negedge clk);
    load_i = 1'b0;
    step_i = 1'b0;
  endtask

  function automatic longint exp_phys(input int a);
    if (word_mode_i) return longint'(page_i >> 1) * 131072 + longint'(a) * 2;
    return longint'(page_i) * 65536 + longint'(a);
  endfunction

  task automatic chk_outputs(input bit exp_tc);
    int lane_exp;
    lane_exp = word_mode_i ? 3 : ((m_addr % 2) ? 2 : 1);
    chk(phys_addr_o == exp_phys(m_addr[15:0]), word_mode_i ? "R5 phys" : "R4 phys",
        phys_addr_o, exp_phys(m_addr[15:0]));
    chk(count_o == m_cnt[15:0], "R3 count", count_o, m_cnt[15:0]);
    chk(residue_o == 16'((m_cnt + 1) % 65536), "R10 residue", residue_o, (m_cnt + 1) % 65536);
    chk(lane_o == lane_exp[1:0], "R11 lane", lane_o, lane_exp);
    chk(tc_o == exp_tc, "R7 tc", tc_o, exp_tc);
    chk(running_o == m_run, "R7 running", running_o, m_run);
  endtask

  task automatic do_load(input int a, input int c);
    base_addr_i = a[15:0];
    base_count_i = c[15:0];
    tick(1'b1, 1'b0);
    m_addr = a; m_cnt = c; m_run = 1'b1;
    chk_outputs(1'b0);
  endtask

  task automatic do_step();
    bit t;
    t = 1'b0;
    if (m_run) begin
      if (m_cnt == 0) begin
        t = 1'b1;
        if (auto_init_i) begin
          m_addr = base_addr_i; m_cnt = base_count_i;
        end else begin
          m_addr = (m_addr + 1) % 65536; m_cnt = 65535; m_run = 1'b0;
        end
      end else begin
        m_addr = (m_addr + 1) % 65536; m_cnt = m_cnt - 1;
      end
    end
    tick(1'b0, 1'b1);
    chk_outputs(t);
  endtask

  initial begin
    m_addr = 0; m_cnt = 0; m_run = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(count_o == 16'h0 && residue_o == 16'h1, "R1 count/residue", count_o, 0);
    chk(!running_o && !tc_o, "R1 halted", {running_o, tc_o}, 0);
    chk(phys_addr_o == 24'h0, "R1 addr", phys_addr_o, 0);

    // R3 R4 R5 R7 sweep: each count runs to terminal count in both modes
    for (int wm = 0; wm < 2; wm++) begin
      for (int ai = 0; ai < 3; ai++) begin
        for (int c = 0; c < 24; c++) begin
          int a;
          a = (ai == 0) ? 0 : (ai == 1) ? 16'h1235 : 16'hFFF3;
          word_mode_i = wm[0];
          page_i = 8'(8'h5A + c);
          do_load(a, c);
          for (int s = 0; s <= c; s++) do_step();
          // R8 steps while halted ignored
          for (int s = 0; s < 2; s++) do_step();
        end
      end
    end

    // R5 page bit 0 ignored in word mode
    word_mode_i = 1'b1;
    do_load(16'h4321, 5);
    page_i = 8'h36; #1;
    chk(phys_addr_o[23:17] == 7'h1B && phys_addr_o[0] == 1'b0, "R5 page", phys_addr_o, 24'h368642);
    page_i = 8'h37; #1;
    chk(phys_addr_o == 24'h368642, "R5 page0 ignored", phys_addr_o, 24'h368642);

    // R6 wrap within page, both modes
    for (int wm = 0; wm < 2; wm++) begin
      word_mode_i = wm[0];
      page_i = 8'hC3;
      do_load(16'hFFFF, 3);
      do_step();
      chk(count_o == 16'd2 && phys_addr_o == exp_phys(0), "R6 wrap", phys_addr_o, exp_phys(0));
    end

    // R9 auto-init, several rounds
    auto_init_i = 1'b1;
    word_mode_i = 1'b0;
    page_i = 8'h11;
    do_load(16'h0100, 3);
    for (int s = 0; s < 16; s++) do_step();
    chk(running_o, "R9 still running", running_o, 1);
    auto_init_i = 1'b0;

    // R2 load priority over step
    do_load(16'h0200, 7);
    tick(1'b1, 1'b1);
    chk(count_o == 16'd7 && phys_addr_o[15:0] == 16'h0200, "R2 load wins", count_o, 7);

    // R2 load clears tc
    do_load(16'h0010, 0);
    do_step();
    chk(tc_o, "R7 tc set", tc_o, 1);
    do_load(16'h0010, 4);
    chk(!tc_o && running_o, "R2 tc cleared", tc_o, 0);

    // R10 boundary: count 0xFFFF gives residue 0
    do_load(16'h0000, 16'hFFFF);
    chk(residue_o == 16'h0000, "R10 ffff", residue_o, 0);
    do_step();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule